// File: doc/BRIEF.md
# Serial Real Half-Butterfly Stage

This block is one stage of a pipelined FFT for real-valued data that arrives one sample per clock. A single adder/subtractor is shared over two cycles. The two operands of a butterfly enter on consecutive cycles. The output slot after the first operand carries their sum, and the slot after the second operand carries their difference (first minus second). A per-sample bypass forwards a sample unchanged, so the same block can serve in later stages where some samples take no part in a butterfly.

Every sample appears at the output exactly one cycle after it entered, whether it is summed, differenced or bypassed. The surrounding stage sequencer drives the phase and bypass selects for the output slot of the current cycle. The result is one guard bit wider than the input, so the sum or difference of two full-scale samples is always exact.

Top module: `real_halfbfly`

## Requirements
- R1: While reset is held, `out_vld` is 0 and `out_smp` is 0. Reset clears both operand registers to zero, so a difference taken right after reset uses 0 for the not-yet-loaded operand.
- R2: `out_vld` equals `in_vld` of the previous clock cycle.
- R3: With `in_bypass`=0 and `in_phase`=0 (sum phase), `out_smp` is the sign-extended sum of the previous valid sample and the current `in_smp`.
- R4: With `in_bypass`=0 and `in_phase`=1 (difference phase), `out_smp` is the sample two valid inputs back minus the previous valid sample.
- R5: With `in_bypass`=1, `out_smp` is the previous valid sample, sign-extended and unmodified, whatever the value of `in_phase`.
- R6: Inputs are two's complement with DW bits and `out_smp` has DW+1 bits. Sums and differences of full-scale values, for example (-2^(DW-1)) + (-2^(DW-1)), are exact, with no wrap.
- R7: While `out_vld` is 0, `out_smp` is driven to 0.
- R8: If samples a, b, c, d enter on four consecutive cycles with phases 1, 0, 1, 0 and a fifth cycle follows with phase 1, the outputs on cycles 2 to 5 are a+b, a-b, c+d, c-d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Qualifies `in_smp` for this cycle |
| in_smp | input | DW | Two's-complement input sample |
| in_phase | input | 1 | Selects the result for this output slot: 0 gives the sum, 1 gives the difference |
| in_bypass | input | 1 | 1 forwards the previous valid sample unchanged |
| out_vld | output | 1 | Output qualifier, one cycle behind `in_vld` |
| out_smp | output | DW+1 | Two's-complement result |

## Verification
The assertions assume the sequencer alternates the phase select so that a sum slot always follows the first operand of a pair. They also assume `in_smp` holds the second operand whenever a sum is requested. Bypass is assumed to cover both samples of a pair, so it never displaces a pending difference. The directed tasks drive alternating phases for every computed pair and set bypass on whole pairs. They also insert idle cycles only between pairs or after the difference slot, which keeps the stimulus inside these assumptions.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

   // Meaning of the per-cycle phase select.
   typedef enum logic {
      PH_SUM  = 1'b0,
      PH_DIFF = 1'b1
   } rhb_phase_e;

endpackage

// File: rtl/rhb_opnd_regs.sv
// Two-deep operand history: near_q holds the last accepted sample and
// far_q the one accepted before it. Both advance only on valid input.
module rhb_opnd_regs #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] near_q,
   output logic signed [DW-1:0] far_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         near_q <= '0;
         far_q  <= '0;
      end else if (en) begin
         near_q <= din;
         far_q  <= near_q;
      end
   end

endmodule

// File: rtl/rhb_addsub.sv
// The one shared adder. In the sum phase it adds near + din. In the
// difference phase it computes far - near. The operands are steered by
// the phase and the subtraction uses inversion plus carry-in.
module rhb_addsub
   import rhb_pkg::*;
#(
   parameter int DW    = 16,
   parameter int GUARD = 1
) (
   input  rhb_phase_e           phase,
   input  logic signed [DW-1:0] din,
   input  logic signed [DW-1:0] near_q,
   input  logic signed [DW-1:0] far_q,
   output logic        [DW+GUARD-1:0] res
);

   localparam int OW = DW + GUARD;

   logic              sub;
   logic signed [OW-1:0] lhs_x;
   logic signed [OW-1:0] rhs_x;
   logic        [OW-1:0] rhs_m;

   always_comb begin
      sub = (phase == PH_DIFF);
      if (sub) begin
         lhs_x = OW'(far_q);
         rhs_x = OW'(near_q);
      end else begin
         lhs_x = OW'(near_q);
         rhs_x = OW'(din);
      end
      rhs_m = rhs_x ^ {OW{sub}};
      res   = lhs_x + rhs_m + OW'(sub);
   end

endmodule

// File: rtl/rhb_outsel.sv
// Output selection: arithmetic result or bypassed sample, zero when idle.
module rhb_outsel #(
   parameter int DW         = 16,
   parameter int GUARD      = 1,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic                   vld_q,
   input  logic                   bypass,
   input  logic signed [DW-1:0]   near_q,
   input  logic [DW+GUARD-1:0]    arith,
   output logic [DW+GUARD-1:0]    dout
);

   localparam int OW = DW + GUARD;

   logic [OW-1:0] pick;

   generate
      if (HAS_BYPASS) begin : g_byp
         logic signed [OW-1:0] near_x;
         assign near_x = OW'(near_q);
         assign pick   = bypass ? near_x : arith;
      end else begin : g_nobyp
         logic unused_ok;
         assign unused_ok = bypass ^ (^near_q);
         assign pick      = arith;
      end
   endgenerate

   assign dout = vld_q ? pick : '0;

endmodule

// File: rtl/real_halfbfly.sv
module real_halfbfly
   import rhb_pkg::*;
#(
   parameter int DW         = 16,
   parameter int GUARD      = 1,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [DW-1:0]       in_smp,
   input  logic                in_phase,
   input  logic                in_bypass,
   output logic                out_vld,
   output logic [DW+GUARD-1:0] out_smp
);

   localparam int OW = DW + GUARD;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("real_halfbfly: DW must be at least 2");
      end
      if (GUARD < 1) begin : g_bad_guard
         $error("real_halfbfly: GUARD must be at least 1");
      end
   endgenerate

   logic signed [DW-1:0] din_s;
   logic signed [DW-1:0] near_q;
   logic signed [DW-1:0] far_q;
   logic [OW-1:0]        arith;
   logic                 vld_q;
   rhb_phase_e           phase;

   assign din_s = $signed(in_smp);
   assign phase = rhb_phase_e'(in_phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= in_vld;
   end

   rhb_opnd_regs #(.DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_vld),
      .din    (din_s),
      .near_q (near_q),
      .far_q  (far_q)
   );

   rhb_addsub #(.DW(DW), .GUARD(GUARD)) u_alu (
      .phase  (phase),
      .din    (din_s),
      .near_q (near_q),
      .far_q  (far_q),
      .res    (arith)
   );

   rhb_outsel #(.DW(DW), .GUARD(GUARD), .HAS_BYPASS(HAS_BYPASS)) u_sel (
      .vld_q  (vld_q),
      .bypass (in_bypass),
      .near_q (near_q),
      .arith  (arith),
      .dout   (out_smp)
   );

   assign out_vld = vld_q;

endmodule

// File: rtl/real_halfbfly_chk.sv
module real_halfbfly_chk #(
   parameter int DW         = 16,
   parameter int GUARD      = 1,
   parameter bit HAS_BYPASS = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_vld,
   input logic [DW-1:0]       in_smp,
   input logic                in_phase,
   input logic                in_bypass,
   input logic                out_vld,
   input logic [DW+GUARD-1:0] out_smp
);

   localparam int OW = DW + GUARD;

   // Independent history of accepted samples.
   logic signed [DW-1:0] h1;
   logic signed [DW-1:0] h2;
   logic [1:0]           seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1   <= '0;
         h2   <= '0;
         seen <= '0;
      end else if (in_vld) begin
         h1 <= $signed(in_smp);
         h2 <= h1;
         if (seen != 2'd2) seen <= seen + 2'd1;
      end
   end

   logic signed [OW-1:0] e_sum;
   logic signed [OW-1:0] e_dif;
   logic signed [OW-1:0] e_byp;
   logic                 byp_eff;

   assign e_sum   = OW'(h1) + OW'($signed(in_smp));
   assign e_dif   = OW'(h2) - OW'(h1);
   assign e_byp   = OW'(h1);
   assign byp_eff = HAS_BYPASS && in_bypass;

   assert_vld_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   assert_vld_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);

   assert_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !byp_eff && !in_phase) |-> (out_smp == e_sum));

   assert_diff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !byp_eff && in_phase && seen == 2'd2) |-> (out_smp == e_dif));

   assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && byp_eff) |-> (out_smp == e_byp));

endmodule

bind real_halfbfly real_halfbfly_chk #(
   .DW(DW), .GUARD(GUARD), .HAS_BYPASS(HAS_BYPASS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_vld    (in_vld),
   .in_smp    (in_smp),
   .in_phase  (in_phase),
   .in_bypass (in_bypass),
   .out_vld   (out_vld),
   .out_smp   (out_smp)
);

// File: tb/sim_real_halfbfly.sv
`timescale 1ns/1ps
module sim_real_halfbfly;

   localparam int DW = 16;
   localparam int OW = DW + 1;
   localparam int SMAX = (1 << (DW-1)) - 1;
   localparam int SMIN = -(1 << (DW-1));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [DW-1:0] in_smp = '0;
   logic          in_phase = 1'b0;
   logic          in_bypass = 1'b0;
   logic          out_vld;
   logic [OW-1:0] out_smp;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench model state: last two accepted samples and last in_vld.
   int m1 = 0;
   int m2 = 0;
   bit mvld = 1'b0;

   always #4 clk = ~clk;

   real_halfbfly #(.DW(DW), .GUARD(1), .HAS_BYPASS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_smp(in_smp),
      .in_phase(in_phase), .in_bypass(in_bypass),
      .out_vld(out_vld), .out_smp(out_smp)
   );

   task automatic check_int(input int act, input int exp, input string rq);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
      end
   endtask

   // One cycle: drive at the falling edge, compare before the next rise.
   task automatic step(input bit v, input int s, input bit ph, input bit byp,
                       input string rq);
      int exp_o;
      bit exp_v;
      @(negedge clk);
      in_vld = v; in_smp = s[DW-1:0]; in_phase = ph; in_bypass = byp;
      #2;
      exp_v = mvld;
      if (!exp_v)   exp_o = 0;
      else if (byp) exp_o = m1;
      else if (ph)  exp_o = m2 - m1;
      else          exp_o = m1 + s;
      check_int(int'(out_vld), int'(exp_v), "R2");
      check_int(int'($signed(out_smp)), exp_o, rq);
      mvld = v;
      if (v) begin m2 = m1; m1 = s; end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; in_vld = 1'b1; in_smp = 16'h5a5a; in_bypass = 1'b1;
      @(negedge clk);
      #2;
      check_int(int'(out_vld), 0, "R1");
      check_int(int'(out_smp), 0, "R1");
      in_vld = 1'b0; in_bypass = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      mvld = 1'b0; m1 = 0; m2 = 0;
   endtask

   task automatic t_reset_clears;
      t_reset();
      step(1, 7, 1, 0, "R1");
      step(1, 3, 1, 0, "R1");   // far register still 0 from reset: 0 - 7
      step(0, 0, 0, 0, "R7");
   endtask

   task automatic t_pair_stream;
      step(1, 100, 1, 0, "R8");
      step(1, 40, 0, 0, "R8");
      step(1, -25, 1, 0, "R8");
      step(1, 60, 0, 0, "R8");
      step(0, 0, 1, 0, "R8");
      step(0, 0, 0, 0, "R7");
   endtask

   task automatic t_sum_diff;
      for (int k = 0; k < 6; k++) begin
         step(1, k * 311 - 900, 1, 0, "R4");
         step(1, 1700 - k * 577, 0, 0, "R3");
      end
      step(0, 0, 1, 0, "R4");
   endtask

   task automatic t_bypass;
      step(1, 1234, 1, 1, "R5");
      step(1, -4321, 0, 1, "R5");
      step(1, 55, 1, 1, "R5");
      step(1, -66, 1, 1, "R5");   // phase value ignored under bypass
      step(1, 9, 0, 1, "R5");
      step(0, 0, 0, 1, "R5");
   endtask

   task automatic t_mixed;
      step(1, 10, 1, 0, "R3");
      step(1, 20, 0, 0, "R3");
      step(1, 30, 1, 0, "R4");   // difference of 10,20 here
      step(1, 40, 0, 1, "R5");   // bypass pair 30,40
      step(1, 50, 1, 1, "R5");
      step(1, 70, 0, 0, "R3");
      step(0, 0, 1, 0, "R4");
   endtask

   task automatic t_fullscale;
      step(1, SMIN, 1, 0, "R6");
      step(1, SMIN, 0, 0, "R6");
      step(1, SMIN, 1, 0, "R6");
      step(1, SMAX, 0, 0, "R6");
      step(1, SMAX, 1, 0, "R6");
      step(1, SMAX, 0, 0, "R6");
      step(1, SMAX, 1, 0, "R6");
      step(1, SMIN, 0, 0, "R6");
      step(0, 0, 1, 0, "R6");
   endtask

   task automatic t_idle;
      step(0, 12345, 0, 0, "R7");
      step(0, -1, 1, 1, "R7");
      step(0, 77, 0, 0, "R7");
   endtask

   initial begin
      t_reset_clears();
      t_pair_stream();
      t_sum_diff();
      t_bypass();
      t_mixed();
      t_fullscale();
      t_idle();
      t_reset_clears();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule